// File: doc/BRIEF.md
# Data-Processing ALU with Flags

This block is the integer execute unit of a small RISC pipeline. In each cycle it takes a first operand, a second operand that has already been through the barrel shifter, a 4-bit operation code, the current condition flags, the shifter's carry-out and a set-flags bit. It produces a 32-bit result, a write-enable for the destination register and the condition flags that should follow the instruction. All three outputs are registered, so they appear one clock after the inputs are presented. The block is meant to sit at the boundary between the execute and memory stages.

Sixteen operations are supported. The arithmetic group has add and subtract, plus a reverse subtract, add with carry in, subtract with carry in and reverse subtract with carry in. The logical group has AND, OR, XOR and bit-clear. The move group has a plain move and a move of the inverted operand. Four test operations compute a result only to set the flags and never write it back. Multiply, divide and address generation belong to other units.

Top module: `alu_dp_top`

## Requirements
- R1: Opcodes ADD=0100, ADC=0101 and CMN=1011 compute rn+op2, with ADC also adding the incoming C flag (flagsIn[1]). In the flags, C is the carry out of bit 31.
- R2: Opcodes SUB=0010, RSB=0011, SBC=0110, RSC=0111 and CMP=1010 compute, in that order: rn-op2, op2-rn, rn-op2-NOT C, op2-rn-NOT C, and rn-op2. All results are modulo 2^32.
- R3: For the subtracting opcodes, C is 1 exactly when the unsigned subtraction does not borrow.
- R4: For every arithmetic opcode that sets flags, V is 1 exactly when the result overflows as a signed two's-complement value.
- R5: Opcodes AND=0000, EOR=0001, ORR=1100 and BIC=1110 compute rn&op2, rn^op2, rn|op2 and rn&~op2. TST=1000 computes the same value as AND, and TEQ=1001 the same value as EOR.
- R6: MOV=1101 gives op2 and MVN=1111 gives ~op2. The value of rn has no effect on either.
- R7: When a logical or move opcode sets flags, C takes the value of shCarry and V keeps the incoming V.
- R8: The test opcodes 1000 to 1011 always drive writeEn low and always update the flags, whatever setFlags is. Every other opcode drives writeEn high.
- R9: A non-test opcode with setFlags low passes flagsIn through to flagsOut unchanged.
- R10: The flags are ordered {N,Z,C,V} as bits [3:0]. When the flags are updated, N equals bit 31 of the result and Z is 1 exactly when the result is zero.
- R11: Outputs are registered with one cycle of latency. A synchronous active-high reset clears result, writeEn and flagsOut to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rnVal | input | 32 | First operand |
| op2Val | input | 32 | Second operand, already shifted |
| opcode | input | 4 | Operation code |
| setFlags | input | 1 | Set-flags request for non-test operations |
| shCarry | input | 1 | Carry-out of the shifter |
| flagsIn | input | 4 | Current flags {N,Z,C,V} |
| result | output | 32 | Registered result |
| writeEn | output | 1 | Registered destination write-enable |
| flagsOut | output | 4 | Registered next flags {N,Z,C,V} |

## Verification
The hardest cases to reach from the ports are the carry-in variants at their boundaries. Examples are an SBC or RSC with C clear, where the extra borrow turns an exact-zero difference into all ones and clears the output carry, and a signed overflow that comes only from the carry term. The stimulus builds these operand pairs directly around zero, 0x7FFFFFFF and 0x80000000 with both values of the incoming carry. It then sweeps every opcode with random operands, random flag inputs and a random set-flags bit against an arithmetic model written separately from the datapath.

// File: rtl/alu_dp_pkg.sv
package alu_dp_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned OPC_W  = 4;
  localparam int unsigned FLAG_W = 4;

  // flag bit positions inside {N,Z,C,V}
  localparam int unsigned FLAG_N = 3;
  localparam int unsigned FLAG_Z = 2;
  localparam int unsigned FLAG_C = 1;
  localparam int unsigned FLAG_V = 0;

  typedef enum logic [OPC_W-1:0] {
    OP_AND = 4'b0000, OP_EOR = 4'b0001, OP_SUB = 4'b0010, OP_RSB = 4'b0011,
    OP_ADD = 4'b0100, OP_ADC = 4'b0101, OP_SBC = 4'b0110, OP_RSC = 4'b0111,
    OP_TST = 4'b1000, OP_TEQ = 4'b1001, OP_CMP = 4'b1010, OP_CMN = 4'b1011,
    OP_ORR = 4'b1100, OP_MOV = 4'b1101, OP_BIC = 4'b1110, OP_MVN = 4'b1111
  } aluOp_e;

  typedef enum logic [1:0] { CIN_ZERO, CIN_ONE, CIN_FLAG } carryIn_e;
  typedef enum logic [1:0] { LG_AND, LG_EOR, LG_ORR, LG_PASS } logicSel_e;

  typedef struct packed {
    logic      useArith;
    logic      invRn;
    logic      invOp2;
    carryIn_e  cinMode;
    logicSel_e logicSel;
    logic      writeRes;
    logic      forceFlags;
  } aluCtrl_t;

endpackage

// File: rtl/alu_dp_ctrl.sv
module alu_dp_ctrl
  import alu_dp_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output aluCtrl_t         ctrl
);

  always_comb begin
    ctrl            = '0;
    ctrl.cinMode    = CIN_ZERO;
    ctrl.logicSel   = LG_PASS;
    ctrl.writeRes   = (opcode[3:2] != 2'b10);
    ctrl.forceFlags = (opcode[3:2] == 2'b10);
    unique case (aluOp_e'(opcode))
      OP_ADD, OP_CMN: ctrl.useArith = 1'b1;
      OP_ADC: begin
        ctrl.useArith = 1'b1;
        ctrl.cinMode  = CIN_FLAG;
      end
      OP_SUB, OP_CMP: begin
        ctrl.useArith = 1'b1;
        ctrl.invOp2   = 1'b1;
        ctrl.cinMode  = CIN_ONE;
      end
      OP_RSB: begin
        ctrl.useArith = 1'b1;
        ctrl.invRn    = 1'b1;
        ctrl.cinMode  = CIN_ONE;
      end
      OP_SBC: begin
        ctrl.useArith = 1'b1;
        ctrl.invOp2   = 1'b1;
        ctrl.cinMode  = CIN_FLAG;
      end
      OP_RSC: begin
        ctrl.useArith = 1'b1;
        ctrl.invRn    = 1'b1;
        ctrl.cinMode  = CIN_FLAG;
      end
      OP_AND, OP_TST: ctrl.logicSel = LG_AND;
      OP_EOR, OP_TEQ: ctrl.logicSel = LG_EOR;
      OP_ORR:         ctrl.logicSel = LG_ORR;
      OP_BIC: begin
        ctrl.logicSel = LG_AND;
        ctrl.invOp2   = 1'b1;
      end
      OP_MOV:         ctrl.logicSel = LG_PASS;
      OP_MVN: begin
        ctrl.logicSel = LG_PASS;
        ctrl.invOp2   = 1'b1;
      end
      default: ctrl.logicSel = LG_PASS;
    endcase
  end

endmodule

// File: rtl/alu_dp_datapath.sv
module alu_dp_datapath
  import alu_dp_pkg::*;
(
  input  aluCtrl_t          ctrl,
  input  logic [DATA_W-1:0] rnVal,
  input  logic [DATA_W-1:0] op2Val,
  input  logic              setFlags,
  input  logic              shCarry,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic [DATA_W-1:0] resNext,
  output logic [FLAG_W-1:0] flagsNext
);

  localparam int unsigned SUM_W = DATA_W + 1;

  logic [DATA_W-1:0] opA;
  logic [DATA_W-1:0] opB;
  logic              carryIn;
  logic [SUM_W-1:0]  sumWide;
  logic [DATA_W-1:0] logicRes;
  logic              arithV;
  logic              doUpdate;

  assign opA = ctrl.invRn  ? ~rnVal  : rnVal;
  assign opB = ctrl.invOp2 ? ~op2Val : op2Val;

  always_comb begin
    unique case (ctrl.cinMode)
      CIN_ONE:  carryIn = 1'b1;
      CIN_FLAG: carryIn = flagsIn[FLAG_C];
      default:  carryIn = 1'b0;
    endcase
  end

  assign sumWide = {1'b0, opA} + {1'b0, opB} + {{DATA_W{1'b0}}, carryIn};
  assign arithV  = (opA[DATA_W-1] == opB[DATA_W-1]) &&
                   (sumWide[DATA_W-1] != opA[DATA_W-1]);

  always_comb begin
    unique case (ctrl.logicSel)
      LG_AND:  logicRes = rnVal & opB;
      LG_EOR:  logicRes = rnVal ^ opB;
      LG_ORR:  logicRes = rnVal | opB;
      default: logicRes = opB;
    endcase
  end

  assign resNext  = ctrl.useArith ? sumWide[DATA_W-1:0] : logicRes;
  assign doUpdate = ctrl.forceFlags | setFlags;

  always_comb begin
    flagsNext = flagsIn;
    if (doUpdate) begin
      flagsNext[FLAG_N] = resNext[DATA_W-1];
      flagsNext[FLAG_Z] = (resNext == '0);
      flagsNext[FLAG_C] = ctrl.useArith ? sumWide[DATA_W] : shCarry;
      flagsNext[FLAG_V] = ctrl.useArith ? arithV : flagsIn[FLAG_V];
    end
  end

endmodule

// File: rtl/alu_dp_top.sv
module alu_dp_top
  import alu_dp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] rnVal,
  input  logic [DATA_W-1:0] op2Val,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              setFlags,
  input  logic              shCarry,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic [DATA_W-1:0] result,
  output logic              writeEn,
  output logic [FLAG_W-1:0] flagsOut
);

  aluCtrl_t          ctrl;
  logic [DATA_W-1:0] resNext;
  logic [FLAG_W-1:0] flagsNext;

  alu_dp_ctrl u_ctrl (
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  alu_dp_datapath u_dp (
    .ctrl      (ctrl),
    .rnVal     (rnVal),
    .op2Val    (op2Val),
    .setFlags  (setFlags),
    .shCarry   (shCarry),
    .flagsIn   (flagsIn),
    .resNext   (resNext),
    .flagsNext (flagsNext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      writeEn  <= 1'b0;
      flagsOut <= '0;
    end else begin
      result   <= resNext;
      writeEn  <= ctrl.writeRes;
      flagsOut <= flagsNext;
    end
  end

endmodule

// File: rtl/alu_dp_checker.sv
module alu_dp_checker
  import alu_dp_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] op2Val,
  input logic [OPC_W-1:0]  opcode,
  input logic              setFlags,
  input logic              shCarry,
  input logic [FLAG_W-1:0] flagsIn,
  input logic [DATA_W-1:0] result,
  input logic              writeEn,
  input logic [FLAG_W-1:0] flagsOut
);

  logic pastValid;
  always_ff @(posedge clk) begin
    if (rst) pastValid <= 1'b0;
    else     pastValid <= 1'b1;
  end

  logic isTest;
  logic isLogicUpd;
  assign isTest     = (opcode[3:2] == 2'b10);
  assign isLogicUpd = (setFlags || isTest) &&
                      !(opcode inside {4'b0010, 4'b0011, 4'b0100, 4'b0101,
                                       4'b0110, 4'b0111, 4'b1010, 4'b1011});

  // R8
  test_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    pastValid && $past(isTest) |-> !writeEn);

  // R9
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    pastValid && $past(!setFlags && !isTest) |-> flagsOut == $past(flagsIn));

  // R10
  nz_from_result_chk: assert property (@(posedge clk) disable iff (rst)
    pastValid && $past(setFlags || isTest) |->
      (flagsOut[FLAG_N] == result[DATA_W-1]) && (flagsOut[FLAG_Z] == (result == '0)));

  // R7
  logic_cv_chk: assert property (@(posedge clk) disable iff (rst)
    pastValid && $past(isLogicUpd) |->
      (flagsOut[FLAG_C] == $past(shCarry)) && (flagsOut[FLAG_V] == $past(flagsIn[FLAG_V])));

  // R6
  mov_pass_chk: assert property (@(posedge clk) disable iff (rst)
    pastValid && $past(opcode == 4'b1101) |-> result == $past(op2Val));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (result == '0) && !writeEn && (flagsOut == '0));

endmodule

bind alu_dp_top alu_dp_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .op2Val   (op2Val),
  .opcode   (opcode),
  .setFlags (setFlags),
  .shCarry  (shCarry),
  .flagsIn  (flagsIn),
  .result   (result),
  .writeEn  (writeEn),
  .flagsOut (flagsOut)
);

// File: tb/alu_dp_top_tb.sv
module alu_dp_top_tb;

  typedef struct {
    logic [31:0] res;
    logic        we;
    logic [3:0]  flg;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] rnVal = '0;
  logic [31:0] op2Val = '0;
  logic [3:0]  opcode = '0;
  logic        setFlags = 1'b0;
  logic        shCarry = 1'b0;
  logic [3:0]  flagsIn = '0;
  logic [31:0] result;
  logic        writeEn;
  logic [3:0]  flagsOut;

  int total = 0;
  int bad = 0;
  expItem_t scoreQ[$];

  always #10 clk = ~clk;

  alu_dp_top u_dut (
    .clk(clk), .rst(rst), .rnVal(rnVal), .op2Val(op2Val), .opcode(opcode),
    .setFlags(setFlags), .shCarry(shCarry), .flagsIn(flagsIn),
    .result(result), .writeEn(writeEn), .flagsOut(flagsOut)
  );

  function automatic expItem_t model(logic [31:0] a, logic [31:0] b, logic [3:0] opc,
                                     logic s, logic shc, logic [3:0] fin, string tag);
    expItem_t e;
    logic [32:0] wide;
    logic [31:0] r;
    logic c, v, arith, test;
    logic cin;
    cin   = fin[1];
    arith = 1'b1;
    c = 1'b0; v = 1'b0;
    case (opc)
      4'b0100, 4'b1011, 4'b0101: begin
        wide = {1'b0, a} + {1'b0, b} + ((opc == 4'b0101) ? {32'd0, cin} : 33'd0);
        r = wide[31:0]; c = wide[32];
        v = (a[31] == b[31]) && (r[31] != a[31]);
      end
      4'b0010, 4'b1010, 4'b0110: begin
        wide = {1'b0, b} + ((opc == 4'b0110 && !cin) ? 33'd1 : 33'd0);
        r = a - wide[31:0];
        if (opc == 4'b0110 && !cin) r = a - b - 32'd1;
        c = ({1'b0, a} >= wide);
        v = (a[31] != b[31]) && (r[31] != a[31]);
      end
      4'b0011, 4'b0111: begin
        wide = {1'b0, a} + ((opc == 4'b0111 && !cin) ? 33'd1 : 33'd0);
        r = b - a;
        if (opc == 4'b0111 && !cin) r = b - a - 32'd1;
        c = ({1'b0, b} >= wide);
        v = (b[31] != a[31]) && (r[31] != b[31]);
      end
      default: begin
        arith = 1'b0;
        case (opc)
          4'b0000, 4'b1000: r = a & b;
          4'b0001, 4'b1001: r = a ^ b;
          4'b1100:          r = a | b;
          4'b1110:          r = a & ~b;
          4'b1101:          r = b;
          default:          r = ~b;
        endcase
        c = shc;
        v = fin[0];
      end
    endcase
    test  = (opc[3:2] == 2'b10);
    e.res = r;
    e.we  = !test;
    e.flg = (s || test) ? {r[31], (r == 32'd0), c, (arith ? v : fin[0])} : fin;
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(logic [31:0] a, logic [31:0] b, logic [3:0] opc,
                       logic s, logic shc, logic [3:0] fin, string tag);
    @(negedge clk);
    rnVal = a; op2Val = b; opcode = opc; setFlags = s; shCarry = shc; flagsIn = fin;
    scoreQ.push_back(model(a, b, opc, s, shc, fin, tag));
  endtask

  // monitor: outputs registered at posedge, compared shortly after
  always @(posedge clk) begin
    #2;
    if (!rst && scoreQ.size() > 0) begin
      expItem_t e;
      e = scoreQ.pop_front();
      total++;
      if (result !== e.res || writeEn !== e.we || flagsOut !== e.flg) begin
        bad++;
        $display("FAIL %s: res=%h we=%b flg=%b expected res=%h we=%b flg=%b",
                 e.tag, result, writeEn, flagsOut, e.res, e.we, e.flg);
      end
    end
  end

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    total++;
    // R11 reset state
    if (result !== '0 || writeEn !== 1'b0 || flagsOut !== '0) begin
      bad++;
      $display("FAIL R11 reset: res=%h we=%b flg=%b expected 0 0 0", result, writeEn, flagsOut);
    end
    @(negedge clk); rst = 1'b0;

    // R1 add family
    drive(32'd1, 32'd2, 4'b0100, 1'b1, 1'b0, 4'b0000, "R1 add");
    drive(32'hFFFF_FFFF, 32'd1, 4'b0100, 1'b1, 1'b0, 4'b0000, "R1 R10 add wrap carry zero");
    drive(32'd10, 32'd20, 4'b0101, 1'b1, 1'b0, 4'b0010, "R1 adc cin1");
    drive(32'hFFFF_FFFF, 32'd0, 4'b0101, 1'b1, 1'b0, 4'b0010, "R1 adc carry only");
    drive(32'd5, 32'hFFFF_FFFB, 4'b1011, 1'b0, 1'b0, 4'b0000, "R1 R8 cmn");
    // R4 overflow
    drive(32'h7FFF_FFFF, 32'd1, 4'b0100, 1'b1, 1'b0, 4'b0000, "R4 add overflow");
    drive(32'h7FFF_FFFF, 32'd0, 4'b0101, 1'b1, 1'b0, 4'b0010, "R4 adc overflow via carry");
    drive(32'h8000_0000, 32'd1, 4'b0010, 1'b1, 1'b0, 4'b0000, "R4 sub overflow");
    // R2 / R3 subtract family
    drive(32'd5, 32'd3, 4'b0010, 1'b1, 1'b0, 4'b0000, "R2 R3 sub no borrow");
    drive(32'd3, 32'd5, 4'b0010, 1'b1, 1'b0, 4'b0000, "R2 R3 sub borrow");
    drive(32'd3, 32'd10, 4'b0011, 1'b1, 1'b0, 4'b0000, "R2 rsb");
    drive(32'd7, 32'd7, 4'b0110, 1'b1, 1'b0, 4'b0000, "R2 R3 sbc c0 equal");
    drive(32'd7, 32'd7, 4'b0110, 1'b1, 1'b0, 4'b0010, "R2 R3 sbc c1 equal");
    drive(32'd4, 32'd4, 4'b0111, 1'b1, 1'b0, 4'b0000, "R2 R3 rsc c0 equal");
    drive(32'd4, 32'd9, 4'b0111, 1'b1, 1'b0, 4'b0010, "R2 rsc c1");
    drive(32'd9, 32'd9, 4'b1010, 1'b0, 1'b0, 4'b0000, "R2 R8 cmp equal");
    // R5 logical
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 4'b0000, 1'b1, 1'b1, 4'b0001, "R5 R7 and");
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 4'b0001, 1'b1, 1'b0, 4'b0000, "R5 eor");
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 4'b1100, 1'b1, 1'b1, 4'b0000, "R5 orr");
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 4'b1110, 1'b1, 1'b0, 4'b0011, "R5 R7 bic");
    // R6 moves ignore rn
    drive(32'hDEAD_BEEF, 32'h0000_00AA, 4'b1101, 1'b0, 1'b0, 4'b0000, "R6 mov");
    drive(32'h1234_5678, 32'h0000_00AA, 4'b1101, 1'b1, 1'b1, 4'b0001, "R6 R7 mov other rn");
    drive(32'hDEAD_BEEF, 32'h0000_0000, 4'b1111, 1'b1, 1'b0, 4'b1111, "R6 R7 mvn");
    // R8 test ops with S=0
    drive(32'h0000_00F0, 32'h0000_000F, 4'b1000, 1'b0, 1'b1, 4'b1001, "R8 tst zero");
    drive(32'hAAAA_AAAA, 32'hAAAA_AAAA, 4'b1001, 1'b0, 1'b0, 4'b0000, "R8 teq equal");
    // R9 S=0 passes flags
    drive(32'hFFFF_FFFF, 32'd1, 4'b0100, 1'b0, 1'b1, 4'b1010, "R9 add no s");
    drive(32'd0, 32'd0, 4'b1110, 1'b0, 1'b1, 4'b0101, "R9 bic no s");
    // sweep with random data
    for (int i = 0; i < 400; i++) begin
      drive($urandom, $urandom, 4'(i % 16), 1'($urandom), 1'($urandom), 4'($urandom),
            "R1 R2 R5 R10 sweep");
    end
    repeat (3) @(posedge clk);
    #5;
    // R11 reset clears after activity
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #2;
    total++;
    if (result !== '0 || writeEn !== 1'b0 || flagsOut !== '0) begin
      bad++;
      $display("FAIL R11 re-reset: res=%h we=%b flg=%b expected 0 0 0", result, writeEn, flagsOut);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule